// File: doc/BRIEF.md
# Instruction Fault Screen

This block sits between the instruction decoder and the execute stage of a small processor pipeline. For every instruction that the decoder marks valid, it looks at the opword and at the fields of the indexed-addressing extension word. It also looks at the decoder's supervisor-only flag and at the current privilege mode. From these it decides whether the instruction must be replaced by an exception. One cycle after the valid strobe it raises a single-cycle request together with the 8-bit vector number that the exception unit should use.

Three fault classes are recognised. An address error (vector 3) comes from one of three things in an indexed extension word: a word-sized index register, an unsupported scale code, or the extension-valid bit set. An illegal instruction (vector 4) comes from exactly two reserved opwords. A privilege violation (vector 8) comes from a supervisor-only instruction issued in user mode. Any other opcode passes, and so does any other extension word content. There is no operand-address input at all. Misaligned data is broken into aligned bus cycles further down the pipeline, so alignment can never raise a fault here.

Top module: `insn_fault_check`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `exc_req` is 0 and `exc_vec` is 8'd0.
- R2: A valid instruction whose opword is 16'h0000 or 16'h4AFC produces `exc_req`=1 with `exc_vec`=8'd4 in the cycle after the strobe.
- R3: A valid instruction with any other opword, no indexed extension fault and no privilege fault produces no request.
- R4: A valid instruction with `priv_insn`=1 while `sup_mode`=0 (user mode) produces `exc_vec`=8'd8. The same instruction with `sup_mode`=1 produces no request.
- R5: A valid instruction with `ext_present`=1 and `ext_idx_word`=1 (index register used as a sign-extended word) produces `exc_vec`=8'd3.
- R6: A valid instruction with `ext_present`=1 and `ext_scale`=2'b11 (scale by 8, unsupported) produces `exc_vec`=8'd3. Scale codes 2'b00, 2'b01 and 2'b10 (×1, ×2, ×4) are accepted.
- R7: A valid instruction with `ext_present`=1 and `ext_ev`=1 produces `exc_vec`=8'd3.
- R8: When `ext_present`=0, the extension fields `ext_idx_word`, `ext_scale` and `ext_ev` have no effect on the result.
- R9: When several faults hold at once, the vector chosen is 3 before 4 before 8.
- R10: `exc_req` is high only in the cycle after a cycle with `insn_vld`=1, never for two cycles from one strobe, and `exc_vec` is 8'd0 whenever `exc_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_vld | input | 1 | Decoded instruction is present this cycle |
| opword | input | 16 | First instruction word |
| ext_present | input | 1 | Instruction uses an indexed mode with an extension word |
| ext_idx_word | input | 1 | Extension selects a word-sized index register |
| ext_scale | input | 2 | Extension scale code |
| ext_ev | input | 1 | Extension-valid bit of the extension word |
| priv_insn | input | 1 | Decoder marks the instruction supervisor-only |
| sup_mode | input | 1 | 1 = supervisor mode, 0 = user mode |
| exc_req | output | 1 | One-cycle exception request |
| exc_vec | output | 8 | Exception vector number, 0 when idle |

## Verification
On every cycle, the assertions check the vector that follows each single fault condition and the priority order among the faults. They also check that a request always follows a strobe, that it lasts one cycle, and that the vector is zero when idle. Some properties need chosen stimulus to show. These are: that untouched opwords next to the two reserved ones pass, that the three accepted scale codes pass, that the extension fields are ignored without an indexed mode, and that back-to-back faulting instructions each produce their own pulse. The bench's scenarios show these.

// File: rtl/fault_pkg.sv
package fault_pkg;
  localparam int VEC_W = 8;
  localparam int OP_W  = 16;
  localparam int SC_W  = 2;

  localparam logic [VEC_W-1:0] VEC_NONE    = 8'd0;
  localparam logic [VEC_W-1:0] VEC_ADDRERR = 8'd3;
  localparam logic [VEC_W-1:0] VEC_ILLEGAL = 8'd4;
  localparam logic [VEC_W-1:0] VEC_PRIV    = 8'd8;

  localparam logic [OP_W-1:0] OP_RSVD_ZERO = 16'h0000;
  localparam logic [OP_W-1:0] OP_RSVD_ILL  = 16'h4AFC;

  typedef struct packed {
    logic            present;
    logic            idx_word;
    logic [SC_W-1:0] scale;
    logic            ev;
  } ext_fields_t;

  typedef struct packed {
    logic addr;
    logic ill;
    logic priv;
  } fault_set_t;
endpackage

// File: rtl/opword_screen.sv
module opword_screen
  import fault_pkg::*;
#(
  parameter int NUM_RSVD = 2
) (
  input  logic [OP_W-1:0] opword,
  output logic            is_illegal
);
  logic [OP_W-1:0] rsvd [NUM_RSVD];
  logic [NUM_RSVD-1:0] hit;

  always_comb begin
    for (int k = 0; k < NUM_RSVD; k++) rsvd[k] = '0;
    rsvd[0] = OP_RSVD_ZERO;
    if (NUM_RSVD > 1) rsvd[NUM_RSVD-1] = OP_RSVD_ILL;
  end

  for (genvar g = 0; g < NUM_RSVD; g++) begin : g_cmp
    assign hit[g] = (opword == rsvd[g]);
  end

  assign is_illegal = |hit;
endmodule

// File: rtl/index_ext_screen.sv
module index_ext_screen
  import fault_pkg::*;
#(
  parameter int MAX_SCALE_CODE = 2
) (
  input  ext_fields_t ext,
  output logic        addr_fault
);
  logic bad_size, bad_scale, bad_ev;

  always_comb begin
    bad_size  = ext.idx_word;
    bad_scale = (int'(ext.scale) > MAX_SCALE_CODE);
    bad_ev    = ext.ev;
    addr_fault = ext.present & (bad_size | bad_scale | bad_ev);
  end
endmodule

// File: rtl/fault_arbiter.sv
module fault_arbiter
  import fault_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  fault_set_t       faults,
  output logic             req,
  output logic [VEC_W-1:0] vec
);
  logic             any_fault;
  logic [VEC_W-1:0] sel_vec;

  always_comb begin
    any_fault = faults.addr | faults.ill | faults.priv;
    if (faults.addr)      sel_vec = VEC_ADDRERR;
    else if (faults.ill)  sel_vec = VEC_ILLEGAL;
    else if (faults.priv) sel_vec = VEC_PRIV;
    else                  sel_vec = VEC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
      vec <= VEC_NONE;
    end else if (vld && any_fault) begin
      req <= 1'b1;
      vec <= sel_vec;
    end else begin
      req <= 1'b0;
      vec <= VEC_NONE;
    end
  end
endmodule

// File: rtl/insn_fault_check.sv
module insn_fault_check
  import fault_pkg::*;
#(
  parameter int MAX_SCALE_CODE = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             insn_vld,
  input  logic [OP_W-1:0]  opword,
  input  logic             ext_present,
  input  logic             ext_idx_word,
  input  logic [SC_W-1:0]  ext_scale,
  input  logic             ext_ev,
  input  logic             priv_insn,
  input  logic             sup_mode,
  output logic             exc_req,
  output logic [VEC_W-1:0] exc_vec
);
  ext_fields_t ext;
  fault_set_t  faults;
  logic        ill_hit;
  logic        addr_hit;

  assign ext = '{present: ext_present, idx_word: ext_idx_word,
                 scale: ext_scale, ev: ext_ev};

  opword_screen #(.NUM_RSVD(2)) u_op (
    .opword     (opword),
    .is_illegal (ill_hit)
  );

  index_ext_screen #(.MAX_SCALE_CODE(MAX_SCALE_CODE)) u_ext (
    .ext        (ext),
    .addr_fault (addr_hit)
  );

  assign faults = '{addr: addr_hit, ill: ill_hit, priv: priv_insn & ~sup_mode};

  fault_arbiter u_arb (
    .clk    (clk),
    .rst    (rst),
    .vld    (insn_vld),
    .faults (faults),
    .req    (exc_req),
    .vec    (exc_vec)
  );
endmodule

// File: rtl/insn_fault_check_sva.sv
module insn_fault_check_sva
  import fault_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             insn_vld,
  input logic [OP_W-1:0]  opword,
  input logic             ext_present,
  input logic             ext_idx_word,
  input logic [SC_W-1:0]  ext_scale,
  input logic             ext_ev,
  input logic             priv_insn,
  input logic             sup_mode,
  input logic             exc_req,
  input logic [VEC_W-1:0] exc_vec
);
  logic ext_bad, op_bad, priv_bad;
  assign ext_bad  = ext_present && (ext_idx_word || ext_scale == 2'b11 || ext_ev);
  assign op_bad   = (opword == 16'h0000) || (opword == 16'h4AFC);
  assign priv_bad = priv_insn && !sup_mode;

  AST_ILLEGAL_VEC: assert property (@(posedge clk) disable iff (rst)
    insn_vld && op_bad && !ext_bad |=> exc_req && exc_vec == 8'd4); // R2
  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (rst)
    insn_vld && !op_bad && !ext_bad && !priv_bad |=> !exc_req); // R3
  AST_PRIV_VEC: assert property (@(posedge clk) disable iff (rst)
    insn_vld && priv_bad && !op_bad && !ext_bad |=> exc_req && exc_vec == 8'd8); // R4
  AST_IDX_WORD: assert property (@(posedge clk) disable iff (rst)
    insn_vld && ext_present && ext_idx_word |=> exc_req && exc_vec == 8'd3); // R5
  AST_BAD_SCALE: assert property (@(posedge clk) disable iff (rst)
    insn_vld && ext_present && ext_scale == 2'b11 |=> exc_req && exc_vec == 8'd3); // R6
  AST_EV_SET: assert property (@(posedge clk) disable iff (rst)
    insn_vld && ext_present && ext_ev |=> exc_req && exc_vec == 8'd3); // R7
  AST_ILL_OVER_PRIV: assert property (@(posedge clk) disable iff (rst)
    insn_vld && op_bad && priv_bad && !ext_bad |=> exc_vec == 8'd4); // R9
  AST_REQ_AFTER_VLD: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> $past(insn_vld)); // R10
  AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (rst)
    !exc_req |-> exc_vec == 8'd0); // R10
  AST_NO_STRETCH: assert property (@(posedge clk) disable iff (rst)
    !insn_vld |=> !exc_req); // R10
endmodule

bind insn_fault_check insn_fault_check_sva u_sva (
  .clk(clk), .rst(rst), .insn_vld(insn_vld), .opword(opword),
  .ext_present(ext_present), .ext_idx_word(ext_idx_word),
  .ext_scale(ext_scale), .ext_ev(ext_ev), .priv_insn(priv_insn),
  .sup_mode(sup_mode), .exc_req(exc_req), .exc_vec(exc_vec)
);

// File: tb/insn_fault_check_tb.sv
module insn_fault_check_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_vld = 1'b0;
  logic [15:0] opword = 16'h1234;
  logic        ext_present = 1'b0;
  logic        ext_idx_word = 1'b0;
  logic [1:0]  ext_scale = 2'b00;
  logic        ext_ev = 1'b0;
  logic        priv_insn = 1'b0;
  logic        sup_mode = 1'b1;
  logic        exc_req;
  logic [7:0]  exc_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic       req;
    logic [7:0] vec;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  insn_fault_check u_dut (
    .clk(clk), .rst(rst), .insn_vld(insn_vld), .opword(opword),
    .ext_present(ext_present), .ext_idx_word(ext_idx_word),
    .ext_scale(ext_scale), .ext_ev(ext_ev), .priv_insn(priv_insn),
    .sup_mode(sup_mode), .exc_req(exc_req), .exc_vec(exc_vec)
  );

  task automatic check(input string tag, input logic req_a, input logic [7:0] vec_a,
                       input logic req_e, input logic [7:0] vec_e);
    checks++;
    if (req_a !== req_e || vec_a !== vec_e) begin
      errors++;
      $display("FAIL %s: req=%0b vec=%0d, expected req=%0b vec=%0d",
               tag, req_a, vec_a, req_e, vec_e);
    end
  endtask

  // Expected result computed from the requirements alone
  function automatic exp_t model(input logic v, input logic [15:0] op, input logic ep,
                                 input logic iw, input logic [1:0] sc, input logic ev,
                                 input logic pi, input logic sm, input string tag);
    exp_t e;
    e.tag = tag;
    e.req = 1'b0;
    e.vec = 8'd0;
    if (v) begin
      if (ep && (iw || sc == 2'b11 || ev)) begin e.req = 1'b1; e.vec = 8'd3; end
      else if (op == 16'h0000 || op == 16'h4AFC) begin e.req = 1'b1; e.vec = 8'd4; end
      else if (pi && !sm) begin e.req = 1'b1; e.vec = 8'd8; end
    end
    return e;
  endfunction

  task automatic drive(input string tag, input logic v, input logic [15:0] op,
                       input logic ep, input logic iw, input logic [1:0] sc,
                       input logic ev, input logic pi, input logic sm);
    @(negedge clk);
    insn_vld = v; opword = op; ext_present = ep; ext_idx_word = iw;
    ext_scale = sc; ext_ev = ev; priv_insn = pi; sup_mode = sm;
    sb.push_back(model(v, op, ep, iw, sc, ev, pi, sm, tag));
  endtask

  // Monitor: compares one expected item per clock after the driver pushed it
  always @(posedge clk) begin
    #1;
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, exc_req, exc_vec, e.req, e.vec);
    end
  end

  initial begin
    // R1: reset state, with a faulting opword held on the inputs
    insn_vld = 1'b1; opword = 16'h0000;
    repeat (3) @(negedge clk);
    check("R1 during reset", exc_req, exc_vec, 1'b0, 8'd0);
    rst = 1'b0; insn_vld = 1'b0; opword = 16'h1234;
    @(negedge clk);
    check("R1 after release", exc_req, exc_vec, 1'b0, 8'd0);

    drive("R2 op 0000",        1, 16'h0000, 0,0,2'b00,0, 0,1);
    drive("R2 op 4AFC",        1, 16'h4AFC, 0,0,2'b00,0, 0,0);
    drive("R3 op 4AFD",        1, 16'h4AFD, 0,0,2'b00,0, 0,1);
    drive("R3 op 0001",        1, 16'h0001, 0,0,2'b00,0, 0,1);
    drive("R3 op FFFF",        1, 16'hFFFF, 0,0,2'b00,0, 0,0);
    drive("R4 priv user",      1, 16'h46FC, 0,0,2'b00,0, 1,0);
    drive("R4 priv super",     1, 16'h46FC, 0,0,2'b00,0, 1,1);
    drive("R5 word index",     1, 16'h2030, 1,1,2'b00,0, 0,1);
    drive("R6 scale x8",       1, 16'h2030, 1,0,2'b11,0, 0,1);
    drive("R6 scale x1",       1, 16'h2030, 1,0,2'b00,0, 0,1);
    drive("R6 scale x2",       1, 16'h2030, 1,0,2'b01,0, 0,1);
    drive("R6 scale x4",       1, 16'h2030, 1,0,2'b10,0, 0,1);
    drive("R7 ev set",         1, 16'h2030, 1,0,2'b00,1, 0,1);
    drive("R8 ext ignored",    1, 16'h2030, 0,1,2'b11,1, 0,1);
    drive("R8 ext ignored op", 1, 16'h0000, 0,1,2'b11,1, 0,1);
    drive("R9 addr over ill",  1, 16'h4AFC, 1,0,2'b11,0, 1,0);
    drive("R9 ill over priv",  1, 16'h0000, 0,0,2'b00,0, 1,0);
    drive("R9 addr over priv", 1, 16'h46FC, 1,0,2'b00,1, 1,0);
    drive("R10 no strobe",     0, 16'h0000, 1,1,2'b11,1, 1,0);
    drive("R10 single pulse",  0, 16'h1234, 0,0,2'b00,0, 0,1);
    drive("R10 back to back a",1, 16'h4AFC, 0,0,2'b00,0, 0,1);
    drive("R10 back to back b",1, 16'h46FC, 0,0,2'b00,0, 1,0);
    drive("R10 idle after",    0, 16'h1234, 0,0,2'b00,0, 0,1);
    drive("R10 idle again",    0, 16'h1234, 0,0,2'b00,0, 0,1);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule